// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block decides which received ARINC 429 words one receive channel keeps. A serial deserializer outside the block hands it finished 32-bit words, each marked by a one-cycle valid strobe. Each word may be screened in three ways, and each screen is switched on by the control register: by label, against a 16-entry label table; by the two source/destination bits; and by odd parity over the whole word. Words that pass all enabled screens are written into a four-word FIFO. If the channel is set to reverse the label, the stored label byte is bit-reversed.

Software writes the 10-bit channel configuration into the control register. Any write to this register empties the FIFO. The label table is loaded one entry at a time. When fewer than 16 labels are wanted, the spare entries hold copies of a wanted label. The channel reports FIFO empty and FIFO full, and raises an interrupt flag whose meaning is set in the control register. The bit-rate selection is passed out unchanged to the deserializer.

Word bit numbering: ARINC bit n sits at `wordIn[n-1]`. The label is `wordIn[7:0]`, the source/destination bits 9 and 10 are `wordIn[8]` and `wordIn[9]`, and bit 32 is `wordIn[31]`.

Top module: `arinc_word_filter`

## Requirements
- R1: With control bit 2 set, a word is kept only if its label (after any reversal per R4) equals one of the 16 label-table entries. With bit 2 clear, the label is not checked.
- R2: With control bit 6 set, a word is kept only if `wordIn[9]` equals control bit 7 and `wordIn[8]` equals control bit 8. With bit 6 clear, these bits are not checked.
- R3: With control bit 4 set, a word is kept only if the XOR of all 32 bits is 1. With bit 4 clear, `wordIn[31]` is ordinary data and has no effect on acceptance.
- R4: With control bit 9 set, the label byte is stored as received. With bit 9 clear, `wordIn[7:0]` is stored bit-reversed (bit 0 swaps with bit 7, and so on). Bits 31:8 are stored unchanged.
- R5: Kept words leave the FIFO in arrival order. `fifoRdData` shows the oldest word, and `fifoRdEn` removes it. While the FIFO is empty, `fifoRdData` is all zeros.
- R6: The FIFO holds four words. A word that passes the screens while the FIFO is full is discarded, and the stored words are unchanged.
- R7: `flag` equals "FIFO not empty" when control bit 1 is 0, and "FIFO full" when control bit 1 is 1.
- R8: Any control register write empties the FIFO. While control bit 3 is 1, the FIFO stays empty and incoming words are ignored.
- R9: `rateLow` follows control bit 0 (1 selects the low-speed divide-by-80 rate, 0 selects divide-by-10).
- R10: `ctrlRdData` returns the written bits 9:0 and zeros in bits 15:10.
- R11: `fifoEmpty` and `fifoFull` show a count of zero and a count of four. Both change in the cycle after the clock edge that stores or removes a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe (also empties the FIFO) |
| ctrlWrData | input | 16 | Control register write value |
| ctrlRdData | output | 16 | Control register read value |
| lblWrEn | input | 1 | Label table write strobe |
| lblWrIdx | input | 4 | Label table entry index |
| lblWrData | input | 8 | Label value to store |
| wordValid | input | 1 | One-cycle strobe marking a finished word |
| wordIn | input | 32 | Received word |
| fifoRdEn | input | 1 | Remove the oldest FIFO word |
| fifoRdData | output | 32 | Oldest FIFO word, or zero if empty |
| fifoEmpty | output | 1 | FIFO holds no word |
| fifoFull | output | 1 | FIFO holds four words |
| flag | output | 1 | Interrupt flag, meaning set by control bit 1 |
| rateLow | output | 1 | Bit-rate selection for the deserializer |

## Verification
The assertions assume that `wordValid` is a strobe seen only on finished words, and that reads are requested only through `fifoRdEn`; neither input needs any protocol beyond that. The stimulus drives every input on the falling edge, so the data under each strobe is stable at the rising edge. The stimulus never writes the control register and presents a word in the same cycle. It never holds `fifoRdEn` for more than one cycle before sampling again, so each pop matches one expected word.

// File: rtl/afw_pkg.sv
package afw_pkg;
  localparam int WORD_W = 32;
  localparam int LBL_W  = 8;
  localparam int CTRL_W = 16;

  // Control fields, MSB first; bit positions are part of the register layout.
  typedef struct packed {
    logic lblFwd;      // 9: 1 = label kept as received, 0 = reversed
    logic sdBit9;      // 8: required value of wordIn[8]
    logic sdBit10;     // 7: required value of wordIn[9]
    logic sdEn;        // 6
    logic loopSel;     // 5: stored only
    logic parityEn;    // 4
    logic hold;        // 3
    logic lblEn;       // 2
    logic flagOnFull;  // 1
    logic rateLow;     // 0
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoCmd_t;
endpackage

// File: rtl/afw_ctrl.sv
module afw_ctrl
  import afw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWrEn,
  input  logic [CTRL_W-1:0]   ctrlWrData,
  input  logic                wordValid,
  input  logic [WORD_W-1:0]   wordIn,
  input  logic                labelHit,
  input  logic                fifoFull,
  input  logic                fifoEmpty,
  input  logic                fifoRdEn,
  output cfg_t                cfg,
  output fifoCmd_t            cmd,
  output logic [CTRL_W-1:0]   ctrlRdData,
  output logic                flag
);
  logic lblOk, sdOk, parOk, chanOn;

  always_ff @(posedge clk) begin
    if (!rstN)         cfg <= '0;
    else if (ctrlWrEn) cfg <= cfg_t'(ctrlWrData[CFG_W-1:0]);
  end

  assign ctrlRdData = {{(CTRL_W-CFG_W){1'b0}}, cfg};

  always_comb begin
    lblOk  = !cfg.lblEn || labelHit;
    sdOk   = !cfg.sdEn || (wordIn[9] == cfg.sdBit10 && wordIn[8] == cfg.sdBit9);
    parOk  = !cfg.parityEn || (^wordIn);
    chanOn = !cfg.hold && !ctrlWrEn;
    cmd.clear = ctrlWrEn || cfg.hold;
    cmd.push  = wordValid && chanOn && lblOk && sdOk && parOk && !fifoFull;
    cmd.pop   = fifoRdEn && !fifoEmpty && !cmd.clear;
  end

  assign flag = cfg.flagOnFull ? fifoFull : !fifoEmpty;
endmodule

// File: rtl/afw_datapath.sv
module afw_datapath
  import afw_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int LBL_NUM = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int IDX_W  = $clog2(LBL_NUM)
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfg_t               cfg,
  input  fifoCmd_t           cmd,
  input  logic               lblWrEn,
  input  logic [IDX_W-1:0]   lblWrIdx,
  input  logic [LBL_W-1:0]   lblWrData,
  input  logic [WORD_W-1:0]  wordIn,
  output logic               labelHit,
  output logic [WORD_W-1:0]  fifoRdData,
  output logic               fifoEmpty,
  output logic               fifoFull
);
  logic [LBL_W-1:0]  lblMem [LBL_NUM];
  logic [LBL_W-1:0]  lblRev, lblAdj;
  logic [LBL_NUM-1:0] hitVec;
  logic [WORD_W-1:0] fifoMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  for (genvar b = 0; b < LBL_W; b++) begin : g_rev
    assign lblRev[b] = wordIn[LBL_W-1-b];
  end
  assign lblAdj = cfg.lblFwd ? wordIn[LBL_W-1:0] : lblRev;

  for (genvar i = 0; i < LBL_NUM; i++) begin : g_lbl
    always_ff @(posedge clk) begin
      if (!rstN)                                     lblMem[i] <= '0;
      else if (lblWrEn && lblWrIdx == IDX_W'(i))     lblMem[i] <= lblWrData;
    end
    assign hitVec[i] = (lblMem[i] == lblAdj);
  end
  assign labelHit = |hitVec;

  always_ff @(posedge clk) begin
    if (cmd.push) fifoMem[wrPtr] <= {wordIn[WORD_W-1:LBL_W], lblAdj};
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + 1'b1;
      if (cmd.pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(cmd.push) - CNT_W'(cmd.pop);
    end
  end

  assign fifoEmpty  = (count == '0);
  assign fifoFull   = (count == CNT_W'(DEPTH));
  assign fifoRdData = fifoEmpty ? '0 : fifoMem[rdPtr];

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> count < CNT_W'(DEPTH));
  p_label_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && cfg.lblEn) |-> labelHit);
  p_srcdst_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && cfg.sdEn) |-> (wordIn[9] == cfg.sdBit10 && wordIn[8] == cfg.sdBit9));
  p_parity_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && cfg.parityEn) |-> (^wordIn));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> fifoEmpty);
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> fifoRdData == '0);
endmodule

// File: rtl/arinc_word_filter.sv
module arinc_word_filter
  import afw_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int LBL_NUM = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ctrlWrEn,
  input  logic [15:0]                 ctrlWrData,
  output logic [15:0]                 ctrlRdData,
  input  logic                        lblWrEn,
  input  logic [$clog2(LBL_NUM)-1:0]  lblWrIdx,
  input  logic [7:0]                  lblWrData,
  input  logic                        wordValid,
  input  logic [31:0]                 wordIn,
  input  logic                        fifoRdEn,
  output logic [31:0]                 fifoRdData,
  output logic                        fifoEmpty,
  output logic                        fifoFull,
  output logic                        flag,
  output logic                        rateLow
);
  cfg_t     cfg;
  fifoCmd_t cmd;
  logic     labelHit;

  afw_ctrl u_ctrl (
    .clk, .rstN, .ctrlWrEn, .ctrlWrData, .wordValid, .wordIn,
    .labelHit, .fifoFull, .fifoEmpty, .fifoRdEn,
    .cfg, .cmd, .ctrlRdData, .flag
  );

  afw_datapath #(.DEPTH(DEPTH), .LBL_NUM(LBL_NUM)) u_dp (
    .clk, .rstN, .cfg, .cmd, .lblWrEn, .lblWrIdx, .lblWrData, .wordIn,
    .labelHit, .fifoRdData, .fifoEmpty, .fifoFull
  );

  assign rateLow = cfg.rateLow;
endmodule

// File: tb/arinc_word_filter_bench.sv
module arinc_word_filter_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        ctrlWrEn = 0;
  logic [15:0] ctrlWrData = '0;
  logic [15:0] ctrlRdData;
  logic        lblWrEn = 0;
  logic [3:0]  lblWrIdx = '0;
  logic [7:0]  lblWrData = '0;
  logic        wordValid = 0;
  logic [31:0] wordIn = '0;
  logic        fifoRdEn = 0;
  logic [31:0] fifoRdData;
  logic        fifoEmpty, fifoFull, flag, rateLow;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  arinc_word_filter u_arinc_word_filter (.*);

  // {ctrl, word, accepted}
  localparam logic [48:0] VEC [11] = '{
    {16'h0200, 32'h0000_0077, 1'b1},  // R1 off: any label
    {16'h0204, 32'h0000_0031, 1'b1},  // R1 hit
    {16'h0204, 32'h0000_0032, 1'b0},  // R1 miss
    {16'h0004, 32'h0000_008C, 1'b1},  // R4 reversed then hit
    {16'h0004, 32'h0000_0031, 1'b0},  // R4 reversed then miss
    {16'h0210, 32'h0000_0001, 1'b1},  // R3 odd
    {16'h0210, 32'h0000_0003, 1'b0},  // R3 even
    {16'h0200, 32'h8000_0000, 1'b1},  // R3 off: bit 32 is data
    {16'h02C0, 32'h0000_0200, 1'b1},  // R2 match 10=1,9=0
    {16'h02C0, 32'h0000_0100, 1'b0},  // R2 mismatch
    {16'h0340, 32'h0000_0100, 1'b1}   // R2 match 10=0,9=1
  };

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [15:0] v);
    @(negedge clk); ctrlWrEn = 1; ctrlWrData = v;
    @(negedge clk); ctrlWrEn = 0;
  endtask

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk); wordValid = 1; wordIn = w;
    @(negedge clk); wordValid = 0;
  endtask

  task automatic popWord();
    @(negedge clk); fifoRdEn = 1;
    @(negedge clk); fifoRdEn = 0;
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] expW;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R11 reset empty", 32'(fifoEmpty), 1);
    check("R11 reset full", 32'(fifoFull), 0);
    check("R7 reset flag", 32'(flag), 0);
    check("R5 reset read zero", fifoRdData, 0);
    check("R10 reset ctrl", 32'(ctrlRdData), 0);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk); lblWrEn = 1; lblWrIdx = 4'(i);
      lblWrData = (i == 0) ? 8'h31 : 8'h0F;
    end
    @(negedge clk); lblWrEn = 0;

    foreach (VEC[k]) begin
      writeCtrl(VEC[k][48:33]);
      sendWord(VEC[k][32:1]);
      check($sformatf("R1 R2 R3 vector %0d kept", k), 32'(!fifoEmpty), 32'(VEC[k][0]));
      if (VEC[k][0]) begin
        expW = VEC[k][32:1];
        if (!VEC[k][42]) expW[7:0] = rev8(expW[7:0]);
        check($sformatf("R4 vector %0d stored", k), fifoRdData, expW);
        popWord();
      end
    end

    // R5/R6/R11 fill past depth
    writeCtrl(16'h0200);
    for (int i = 0; i < 5; i++) begin
      sendWord(32'h1000 + 32'(i));
      check("R11 full timing", 32'(fifoFull), (i >= 3) ? 1 : 0);
    end
    for (int i = 0; i < 4; i++) begin
      check("R5 R6 order", fifoRdData, 32'h1000 + 32'(i));
      popWord();
    end
    check("R11 empty after drain", 32'(fifoEmpty), 1);
    check("R5 empty read zero", fifoRdData, 0);

    // R7 flag modes
    sendWord(32'h5);
    check("R7 flag not-empty mode", 32'(flag), 1);
    writeCtrl(16'h0202);
    check("R8 ctrl write clears", 32'(fifoEmpty), 1);
    sendWord(32'h6);
    check("R7 flag full mode one word", 32'(flag), 0);
    for (int i = 0; i < 3; i++) sendWord(32'h7);
    check("R7 flag full mode full", 32'(flag), 1);

    // R8 hold
    writeCtrl(16'h0208);
    sendWord(32'h9);
    check("R8 hold ignores word", 32'(fifoEmpty), 1);
    check("R8 hold read zero", fifoRdData, 0);

    // R9, R10
    writeCtrl(16'h0201);
    check("R9 rate low", 32'(rateLow), 1);
    writeCtrl(16'h0200);
    check("R9 rate high", 32'(rateLow), 0);
    writeCtrl(16'hFFFF);
    check("R10 readback", 32'(ctrlRdData), 32'h03FF);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule